// File: doc/BRIEF.md
# Fine-Resolution Compare PWM Generator

This block drives one output pin with a pulse-width-modulated waveform. Its timebase has two parts. A coarse loop counter runs from zero up to a programmable limit and then wraps. Inside every coarse step, a 7-bit fine counter walks through 128 fine clocks. The two counters are joined as `{coarse, fine}` to form a composite count. This count is compared against a programmed threshold using greater-or-equal semantics. A match applies one of four pin actions. The two pulse-type actions also drive the pin to the other level at the start of each period.

Software-style configuration is written through a single strobe into a shadow set of registers. The shadow set holds the coarse limit, threshold, action and compare mode. It becomes active only when the period wraps, so a change of duty or polarity never cuts a period short. In fine mode the threshold resolves single fine clocks. The threshold can therefore reach past the coarse limit, up to `(limit << 7) + 0x7F`. In coarse mode the low seven threshold bits are ignored and matches are tested once per coarse step. Both extremes of duty, fully off and fully on, come out without any one-clock spike.

Top module: `hires_pwm`

## Requirements
- R1: A synchronous active-low reset clears both counters and the shadow and active configuration. The active configuration becomes limit 0, threshold 0, action CLEAR and coarse mode. The pin is driven low and stays low until a new configuration becomes active.
- R2: The fine counter counts 0..127. The coarse counter advances when the fine count is 127 and wraps to 0 after reaching the active limit. One period therefore lasts (limit+1)*128 clocks, and the composite count is 0 at its first clock.
- R3: In fine mode (`fineMode`=1) a match exists whenever `{1'b0, coarse, fine}` >= threshold. The pin register takes the result one clock after the count value it was decided on. With PULSEHI and threshold D < period length P, the pin is high for exactly P-D clocks per period.
- R4: Action encoding on `actSel`: 2'b00 CLEAR drives low, 2'b01 SET drives high, 2'b10 PULSELO drives low, 2'b11 PULSEHI drives high. Bit 0 is the level applied on a match.
- R5: Only PULSELO and PULSEHI apply the opposite level at the period start. With SET or CLEAR and no match, the pin keeps whatever level it had.
- R6: When a match and the period-start opposite action fall in the same clock, the match wins. A threshold of 0 gives a constant matched level with no glitch.
- R7: A threshold greater than `(limit << 7) + 0x7F` never matches. With a pulse action the pin then stays constant at the opposite level.
- R8: Swapping PULSEHI for PULSELO inverts the waveform. With PULSELO, threshold 0 gives 0% high time and a threshold of P gives 100%.
- R9: In coarse mode (`fineMode`=0) the threshold's bits 6:0 are ignored. A match is tested only at fine count 0, as coarse >= threshold[13:7], and the pin holds between those points.
- R10: A one-clock `cfgWr` loads limit, threshold, action and mode into the shadow registers. The active set is replaced only at the period wrap, so the period in progress finishes with the old settings.
- R11: The full composite range is reachable. With limit 0x20 the top threshold 0x107F gives a single high clock per period under PULSEHI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWr | input | 1 | Loads the configuration inputs into the shadow registers |
| maxCount | input | 6 | Coarse loop limit (inclusive) |
| cmpData | input | 14 | Compare threshold on the composite count |
| actSel | input | 2 | Pin action select (encoding in R4) |
| fineMode | input | 1 | 1 = fine compare, 0 = coarse compare |
| pinOut | output | 1 | PWM output pin |

## Verification
The bench goes after the duty extremes first. A threshold of 0 must give a flat output. A design that let the period-start action win would show a one-clock dip each period. A threshold one past the composite top must never match, and an off-by-one comparator would leak a one-clock pulse there. SET and CLEAR with no match are run from the opposite pin level, so a design that applied the period-start action for every action type would visibly flip the pin. The bench also checks several further cases. A write in the middle of a period must leave that period's high time untouched. In coarse mode, thresholds differing only in their low bits must give identical waveforms. With the doc's limit of 0x20, the top threshold must give one clock of high time, which catches a comparator that ignores the fine bits or clamps at the coarse limit.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

  // Number of fine-count bits inside one coarse step (128 fine clocks).
  localparam int FINE_W = 7;

  // Pin action; bit 0 is the level driven on a compare match,
  // bit 1 marks the pulse types that also act at the period start.
  typedef enum logic [1:0] {
    ACT_CLEAR    = 2'b00,
    ACT_SET      = 2'b01,
    ACT_PULSE_LO = 2'b10,
    ACT_PULSE_HI = 2'b11
  } pin_act_e;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic loadActive;   // last clock of the period: copy shadow to active
    logic periodStart;  // composite count is zero
    logic evalPoint;    // fine count is zero (coarse-mode compare point)
  } pwm_strobe_t;

endpackage

// File: rtl/hrpwm_ctrl.sv
module hrpwm_ctrl
  import hrpwm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FINE_W_P = FINE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    activeMax,
  output logic [FINE_W_P-1:0] fineCnt,
  output logic [CNT_W-1:0]    coarseCnt,
  output pwm_strobe_t         strb
);

  localparam logic [FINE_W_P-1:0] FINE_LAST = {FINE_W_P{1'b1}};

  logic fineEnd;
  logic periodEnd;

  assign fineEnd   = (fineCnt == FINE_LAST);
  assign periodEnd = fineEnd && (coarseCnt == activeMax);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fineCnt   <= '0;
      coarseCnt <= '0;
    end else if (periodEnd) begin
      fineCnt   <= '0;
      coarseCnt <= '0;
    end else begin
      fineCnt <= fineCnt + 1'b1;
      if (fineEnd) begin
        coarseCnt <= coarseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadActive  = periodEnd;
    strb.periodStart = (fineCnt == '0) && (coarseCnt == '0);
    strb.evalPoint   = (fineCnt == '0);
  end

endmodule

// File: rtl/hrpwm_cmp.sv
module hrpwm_cmp #(
  parameter int CNT_W  = 6,
  parameter int FINE_W = 7,
  parameter int DATA_W = CNT_W + FINE_W + 1
) (
  input  logic [CNT_W-1:0]  coarseCnt,
  input  logic [FINE_W-1:0] fineCnt,
  input  logic [DATA_W-1:0] threshold,
  input  logic              fineMode,
  input  logic              evalPoint,
  output logic              hit
);

  localparam int COARSE_CMP_W = DATA_W - FINE_W;

  logic [DATA_W-1:0]       composite;
  logic [COARSE_CMP_W-1:0] coarseExt;
  logic                    fineHit;
  logic                    coarseHit;

  assign composite = {1'b0, coarseCnt, fineCnt};
  assign coarseExt = {1'b0, coarseCnt};

  // Fine compare: every clock against the full composite count.
  assign fineHit = (composite >= threshold);

  // Coarse compare: low threshold bits dropped, tested at fine count zero.
  assign coarseHit = evalPoint && (coarseExt >= threshold[DATA_W-1:FINE_W]);

  assign hit = fineMode ? fineHit : coarseHit;

endmodule

// File: rtl/hrpwm_datapath.sv
module hrpwm_datapath
  import hrpwm_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int FINE_W_P = FINE_W,
  parameter int DATA_W   = CNT_W + FINE_W_P + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwm_strobe_t         strb,
  input  logic [FINE_W_P-1:0] fineCnt,
  input  logic [CNT_W-1:0]    coarseCnt,
  input  logic                cfgWr,
  input  logic [CNT_W-1:0]    maxCount,
  input  logic [DATA_W-1:0]   cmpData,
  input  logic [1:0]          actSel,
  input  logic                fineMode,
  output logic [CNT_W-1:0]    activeMax,
  output logic [DATA_W-1:0]   activeData,
  output logic [1:0]          activeAct,
  output logic                activeFine,
  output logic                pinOut
);

  // Shadow configuration, written by the host strobe.
  logic [CNT_W-1:0]  shadowMax;
  logic [DATA_W-1:0] shadowData;
  pin_act_e          shadowAct;
  logic              shadowFine;

  // Active configuration, used by the compare.
  logic [CNT_W-1:0]  curMax;
  logic [DATA_W-1:0] curData;
  pin_act_e          curAct;
  logic              curFine;

  logic cmpHit;
  logic pinQ;
  logic pinNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowMax  <= '0;
      shadowData <= '0;
      shadowAct  <= ACT_CLEAR;
      shadowFine <= 1'b0;
    end else if (cfgWr) begin
      shadowMax  <= maxCount;
      shadowData <= cmpData;
      shadowAct  <= pin_act_e'(actSel);
      shadowFine <= fineMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMax  <= '0;
      curData <= '0;
      curAct  <= ACT_CLEAR;
      curFine <= 1'b0;
    end else if (strb.loadActive) begin
      curMax  <= shadowMax;
      curData <= shadowData;
      curAct  <= shadowAct;
      curFine <= shadowFine;
    end
  end

  hrpwm_cmp #(
    .CNT_W (CNT_W),
    .FINE_W(FINE_W_P),
    .DATA_W(DATA_W)
  ) u_cmp (
    .coarseCnt(coarseCnt),
    .fineCnt  (fineCnt),
    .threshold(curData),
    .fineMode (curFine),
    .evalPoint(strb.evalPoint),
    .hit      (cmpHit)
  );

  // Compare action outranks the period-start opposite action.
  always_comb begin
    pinNext = pinQ;
    if (cmpHit) begin
      pinNext = curAct[0];
    end else if (strb.periodStart && curAct[1]) begin
      pinNext = ~curAct[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ <= 1'b0;
    end else begin
      pinQ <= pinNext;
    end
  end

  assign pinOut     = pinQ;
  assign activeMax  = curMax;
  assign activeData = curData;
  assign activeAct  = curAct;
  assign activeFine = curFine;

endmodule

// File: rtl/hires_pwm.sv
module hires_pwm
  import hrpwm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FINE_W_P = FINE_W,
  localparam int DATA_W = CNT_W + FINE_W_P + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CNT_W-1:0]  maxCount,
  input  logic [DATA_W-1:0] cmpData,
  input  logic [1:0]        actSel,
  input  logic              fineMode,
  output logic              pinOut
);

  logic [FINE_W_P-1:0] fineCnt;
  logic [CNT_W-1:0]    coarseCnt;
  logic [CNT_W-1:0]    activeMax;
  logic [DATA_W-1:0]   activeData;
  logic [1:0]          activeAct;
  logic                activeFine;
  pwm_strobe_t         strb;

  hrpwm_ctrl #(
    .CNT_W   (CNT_W),
    .FINE_W_P(FINE_W_P)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .activeMax(activeMax),
    .fineCnt  (fineCnt),
    .coarseCnt(coarseCnt),
    .strb     (strb)
  );

  hrpwm_datapath #(
    .CNT_W   (CNT_W),
    .FINE_W_P(FINE_W_P),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fineCnt   (fineCnt),
    .coarseCnt (coarseCnt),
    .cfgWr     (cfgWr),
    .maxCount  (maxCount),
    .cmpData   (cmpData),
    .actSel    (actSel),
    .fineMode  (fineMode),
    .activeMax (activeMax),
    .activeData(activeData),
    .activeAct (activeAct),
    .activeFine(activeFine),
    .pinOut    (pinOut)
  );

endmodule

// File: rtl/hires_pwm_chk.sv
module hires_pwm_chk #(
  parameter int CNT_W  = 6,
  parameter int FINE_W = 7,
  parameter int DATA_W = CNT_W + FINE_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              pinOut,
  input logic [FINE_W-1:0] fineCnt,
  input logic [CNT_W-1:0]  coarseCnt,
  input logic [CNT_W-1:0]  activeMax,
  input logic [DATA_W-1:0] activeData,
  input logic [1:0]        activeAct,
  input logic              activeFine,
  input logic              loadActive
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!pinOut && fineCnt == '0 && coarseCnt == '0)); // R1

  AST_COARSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    coarseCnt <= activeMax); // R2

  AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (fineCnt != '0) |-> (fineCnt == $past(fineCnt) + 1'b1)); // R2

  AST_NONPULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!activeAct[1] && pinOut == activeAct[0] && !loadActive)
      |=> (pinOut == $past(activeAct[0]))); // R5

  AST_ZERO_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    (activeData == '0) |=> (pinOut == $past(activeAct[0]))); // R6

  AST_BEYOND_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (activeAct[1] && ({1'b0, activeMax, {FINE_W{1'b1}}} < activeData))
      |=> (pinOut == !$past(activeAct[0]))); // R7

  AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!activeFine && fineCnt != '0) |=> $stable(pinOut)); // R9

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadActive)) |-> ($stable(activeData) && $stable(activeMax))); // R10

endmodule

bind hires_pwm hires_pwm_chk #(
  .CNT_W (CNT_W),
  .FINE_W(FINE_W_P),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pinOut    (pinOut),
  .fineCnt   (fineCnt),
  .coarseCnt (coarseCnt),
  .activeMax (activeMax),
  .activeData(activeData),
  .activeAct (activeAct),
  .activeFine(activeFine),
  .loadActive(strb.loadActive)
);

// File: tb/hires_pwm_tb.sv
module hires_pwm_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [5:0]  maxCount = '0;
  logic [13:0] cmpData = '0;
  logic [1:0]  actSel = '0;
  logic        fineMode = 1'b0;
  logic        pinOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit cmpOn = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hires_pwm u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .maxCount(maxCount),
    .cmpData(cmpData), .actSel(actSel), .fineMode(fineMode), .pinOut(pinOut)
  );

  // ---------------- reference model from the requirements ----------------
  logic [6:0]  mF;
  logic [5:0]  mC;
  logic [5:0]  sMax, aMax;
  logic [13:0] sData, aData;
  logic [1:0]  sAct, aAct;
  logic        sFine, aFine;
  logic        mPin;
  logic [13:0] mComp;
  logic        mHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mF <= '0; mC <= '0; mPin <= 1'b0;
      sMax <= '0; sData <= '0; sAct <= '0; sFine <= 1'b0;
      aMax <= '0; aData <= '0; aAct <= '0; aFine <= 1'b0;
    end else begin
      mComp = {1'b0, mC, mF};
      if (aFine) mHit = (mComp >= aData);
      else       mHit = (mF == 7'd0) && ({1'b0, mC} >= aData[13:7]);
      if (mHit) mPin <= aAct[0];
      else if (mComp == 14'd0 && aAct[1]) mPin <= ~aAct[0];
      if (mF == 7'd127 && mC == aMax) begin
        mF <= '0; mC <= '0;
        aMax <= sMax; aData <= sData; aAct <= sAct; aFine <= sFine;
      end else begin
        mF <= mF + 7'd1;
        if (mF == 7'd127) mC <= mC + 6'd1;
      end
      if (cfgWr) begin
        sMax <= maxCount; sData <= cmpData; sAct <= actSel; sFine <= fineMode;
      end
    end
  end

  // Cycle-by-cycle comparison with the model (R3/R4 waveform).
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      tests++;
      if (pinOut !== mPin) begin
        fails++;
        $display("FAIL R4 per-cycle pin (act=%0d data=%0d): got %0b expected %0b",
                 aAct, aData, pinOut, mPin);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int got, input int exp, input string what);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int expHigh(input int mx, input int d, input int act, input bit fm, input bit prev);
    int p, cnt;
    bit any;
    p = (mx + 1) * 128;
    if (fm) begin
      any = (d < p);
      cnt = any ? (p - d) : 0;
    end else begin
      any = ((d >> 7) <= mx);
      cnt = any ? (mx + 1 - (d >> 7)) * 128 : 0;
    end
    if (act >= 2) return (act % 2 == 1) ? cnt : (p - cnt);
    if (any) return (act == 1) ? p : 0;
    return prev ? p : 0;
  endfunction

  task automatic cfg(input int mx, input int d, input int act, input bit fm);
    @(negedge clk);
    maxCount = mx[5:0]; cmpData = d[13:0]; actSel = act[1:0]; fineMode = fm;
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!(mF == 7'd0 && mC == 6'd0));
  endtask

  task automatic measure(output int highs, output bit prev);
    int p;
    waitStart();
    prev = pinOut;
    p = (int'(aMax) + 1) * 128;
    highs = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (pinOut) highs++;
    end
  endtask

  task automatic runCase(input string tag, input int mx, input int d, input int act,
                         input bit fm, input string what);
    int h;
    bit prev;
    cfg(mx, d, act, fm);
    waitStart();
    waitStart();
    measure(h, prev);
    check(tag, h, expHigh(mx, d, act, fm, prev), what);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int h, gap, rmax, rdata, ract;
    bit prev, rfm, last;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;

    // R1: pin low after reset, stays low over default config
    h = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pinOut) h++;
    end
    check("R1", h, 0, "high clocks after reset");

    // R3: fine GE compare, PULSEHI
    runCase("R3", 2, 100, 3, 1'b1, "PULSEHI fine D=100");
    runCase("R3", 0, 1, 3, 1'b1, "PULSEHI fine D=1");
    // R4: PULSELO level encoding
    runCase("R4", 2, 100, 2, 1'b1, "PULSELO fine D=100");
    // R6: zero threshold, flat high
    runCase("R6", 2, 0, 3, 1'b1, "PULSEHI D=0 full on");
    // R5: SET with no match from high pin, no opposite action
    runCase("R5", 2, 384, 1, 1'b1, "SET no-match keeps high");
    // R8: PULSELO D=0 full off
    runCase("R8", 2, 0, 2, 1'b1, "PULSELO D=0 full off");
    // R5: CLEAR with no match from low pin
    runCase("R5", 2, 384, 0, 1'b1, "CLEAR no-match keeps low");
    runCase("R5", 2, 200, 1, 1'b1, "SET match drives high");
    runCase("R5", 2, 50, 0, 1'b1, "CLEAR match drives low");
    // R7: just past composite top, and far beyond
    runCase("R7", 2, 384, 3, 1'b1, "PULSEHI D=P full off");
    runCase("R7", 2, 14'h3FFF, 3, 1'b1, "PULSEHI D=max full off");
    // R8: PULSELO beyond top gives full on
    runCase("R8", 2, 384, 2, 1'b1, "PULSELO D=P full on");
    // R9: coarse mode ignores fine bits
    runCase("R9", 3, 14'h081, 3, 1'b0, "coarse D=0x81");
    runCase("R9", 3, 14'h0FF, 3, 1'b0, "coarse D=0xFF");
    runCase("R9", 3, 14'h200, 3, 1'b0, "coarse D beyond top");
    // R11: largest reachable threshold with limit 0x20
    runCase("R11", 32, 14'h107F, 3, 1'b1, "limit 0x20 D=0x107F");

    // R2: period length measured between rising edges
    cfg(1, 255, 3, 1'b1);
    waitStart(); waitStart();
    last = pinOut;
    do begin @(negedge clk); if (!last && pinOut) break; last = pinOut; end while (1);
    gap = 0; last = pinOut;
    do begin @(negedge clk); gap++; if (!last && pinOut) break; last = pinOut; end while (1);
    check("R2", gap, 256, "rising-edge spacing limit=1");

    // R10: mid-period write leaves the running period alone
    cfg(1, 128, 3, 1'b1);
    waitStart(); waitStart();
    h = (pinOut) ? 0 : 0;
    for (int i = 0; i < 256; i++) begin
      if (i == 20) begin
        maxCount = 6'd1; cmpData = 14'd0; actSel = 2'd3; fineMode = 1'b1; cfgWr = 1'b1;
      end
      if (i == 21) cfgWr = 1'b0;
      @(negedge clk);
      if (pinOut) h++;
    end
    check("R10", h, 128, "period with mid-period write");
    measure(h, prev);
    check("R10", h, 256, "period after wrap");

    // Random mix
    for (int k = 0; k < 8; k++) begin
      rmax  = $urandom_range(0, 3);
      rdata = $urandom_range(0, (rmax + 1) * 128 + 40);
      ract  = $urandom_range(0, 3);
      rfm   = 1'($urandom_range(0, 1));
      runCase("R3", rmax, rdata, ract, rfm, "random config");
    end

    cmpOn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule